// File: doc/BRIEF.md
# Masked Packed-Integer SIMD Arithmetic Unit

This block does element-wise integer arithmetic on two wide operand vectors. A lane-size control splits the vector into 8-, 16-, 32- or 64-bit lanes. The operations are wrapping add and subtract, saturating add and subtract, absolute value, minimum, maximum and a pure blend. A signedness control picks the signed or unsigned reading for saturation and for min/max.

An opmask with one bit per lane picks which lanes take the computed value. Each lane whose mask bit is clear is either forced to zero or loaded from a separate pass-through source vector, as a mode bit selects.

The result is held in a register. It updates one cycle after a valid strobe, and `out_valid` marks that update. Saturating arithmetic is only defined for 8- and 16-bit lanes. Asking for it at a wider lane size raises a one-cycle illegal indication and leaves the register untouched.

Top module: `simd_masked_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. Lane i occupies bits [i*W +: W], and no carry or borrow crosses a lane boundary.
- R2: `op` = 0 (add) and 1 (subtract) wrap modulo 2^W, and no overflow indication is produced.
- R3: `op` = 2 (saturating add) and 3 (saturating subtract) clamp to the lane's extreme value instead of wrapping. With `is_signed`=1 the range is [-2^(W-1), 2^(W-1)-1]; with `is_signed`=0 it is [0, 2^W-1].
- R4: `op` = 5 (min) and 6 (max) return the smaller or larger of A and B. The comparison is signed when `is_signed`=1 and unsigned when it is 0.
- R5: `op` = 4 returns the absolute value of A's lane, read as signed. The most negative value wraps back to itself.
- R6: With `zero_mode`=1, for ops 0 to 6, every lane whose mask bit is 0 outputs all zeros.
- R7: With `zero_mode`=0, for ops 0 to 6, every lane whose mask bit is 0 outputs the matching lane of `src`.
- R8: `op` = 7 (blend) outputs B's lane where the mask bit is 1 and A's lane where it is 0, whatever the value of `zero_mode`.
- R9: Only the low VEC_W/W bits of `kmask` are used at each lane size. Higher bits have no effect on the result.
- R10: `result` updates on the clock edge after a legal `in_valid`, and `out_valid` is high for exactly that one cycle. At all other times `result` holds its value.
- R11: A saturating op with `lane_sz` of 2 or 3 raises `illegal` for one cycle one edge later. In that case `out_valid` stays low and `result` is unchanged.
- R12: A synchronous reset clears `result`, `out_valid` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0..7) |
| lane_sz | input | 2 | Lane width code |
| is_signed | input | 1 | Signed reading for saturation and min/max |
| zero_mode | input | 1 | 1 = zero masked lanes, 0 = merge from src |
| kmask | input | VEC_W/8 | Per-lane opmask |
| opa | input | VEC_W | Operand A |
| opb | input | VEC_W | Operand B |
| src | input | VEC_W | Pass-through vector for merging |
| result | output | VEC_W | Registered result |
| out_valid | output | 1 | One-cycle pulse on a result update |
| illegal | output | 1 | One-cycle pulse on a rejected request |

## Verification
Every result, `out_valid` pulse and `illegal` pulse is due one clock edge after the strobe that caused it. The bench drives inputs on the falling edge and drops the strobe on the next falling edge. It then samples all outputs at that point, half a cycle after the capturing edge.

One falling edge later, the bench checks that `out_valid` has returned low and that `result` is unchanged. This is how it confirms the hold behaviour. For a rejected request, the bench compares `result` against the last accepted value at the same sample point.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_ADDS  = 3'd2,
    OP_SUBS  = 3'd3,
    OP_ABS   = 3'd4,
    OP_MIN   = 3'd5,
    OP_MAX   = 3'd6,
    OP_BLEND = 3'd7
  } simd_op_e;

  localparam int NUM_SIZES = 4;

  function automatic logic op_saturates(simd_op_e op);
    return (op == OP_ADDS) || (op == OP_SUBS);
  endfunction
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  simd_op_e       op,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] U_MAX = {W{1'b1}};

  logic [W:0]   sum_x, dif_x;
  logic         s_ovf_add, s_ovf_sub, a_lt_b;
  logic [W-1:0] neg_a;

  always_comb begin
    sum_x     = {1'b0, a} + {1'b0, b};
    dif_x     = {1'b0, a} - {1'b0, b};
    neg_a     = ~a + 1'b1;
    s_ovf_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
    s_ovf_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
    if (sgn && (a[W-1] != b[W-1])) a_lt_b = a[W-1];
    else                           a_lt_b = dif_x[W];
  end

  always_comb begin
    unique case (op)
      OP_ADD: y = sum_x[W-1:0];
      OP_SUB: y = dif_x[W-1:0];
      OP_ADDS: begin
        if (sgn) y = s_ovf_add ? (a[W-1] ? S_MIN : S_MAX) : sum_x[W-1:0];
        else     y = sum_x[W] ? U_MAX : sum_x[W-1:0];
      end
      OP_SUBS: begin
        if (sgn) y = s_ovf_sub ? (a[W-1] ? S_MIN : S_MAX) : dif_x[W-1:0];
        else     y = dif_x[W] ? '0 : dif_x[W-1:0];
      end
      OP_ABS:  y = a[W-1] ? neg_a : a;
      OP_MIN:  y = a_lt_b ? a : b;
      OP_MAX:  y = a_lt_b ? b : a;
      default: y = b;
    endcase
  end

  // Guards on the clamp and sign behaviour of this lane
  always_comb begin
    if (op == OP_ADDS && !sgn)
      p_usat_floor_r3: assert (y >= a) else $error("unsigned saturating add fell below A");
    if (op == OP_SUBS && !sgn)
      p_usat_ceiling_r3: assert (y <= a) else $error("unsigned saturating sub rose above A");
    if (op == OP_ABS && a != S_MIN)
      p_abs_nonneg_r5: assert (!y[W-1]) else $error("absolute value negative");
  end
endmodule

// File: rtl/simd_width_slice.sv
module simd_width_slice
  import simd_pkg::*;
#(
  parameter int VEC_W = 512,
  parameter int W     = 8,
  parameter int KW    = VEC_W / 8
) (
  input  simd_op_e          op,
  input  logic              sgn,
  input  logic              zero_mode,
  input  logic [KW-1:0]     kmask,
  input  logic [VEC_W-1:0]  a,
  input  logic [VEC_W-1:0]  b,
  input  logic [VEC_W-1:0]  src,
  output logic [VEC_W-1:0]  y
);
  localparam int NL = VEC_W / W;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [W-1:0] la, lb, ls, lr;
    logic         k;
    assign la = a[i*W +: W];
    assign lb = b[i*W +: W];
    assign ls = src[i*W +: W];
    assign k  = kmask[i];

    simd_lane_alu #(.W(W)) u_alu (
      .op (op),
      .sgn(sgn),
      .a  (la),
      .b  (lb),
      .y  (lr)
    );

    always_comb begin
      if (op == OP_BLEND)  y[i*W +: W] = k ? lb : la;
      else if (k)          y[i*W +: W] = lr;
      else if (zero_mode)  y[i*W +: W] = '0;
      else                 y[i*W +: W] = ls;
    end
  end
endmodule

// File: rtl/simd_masked_alu.sv
module simd_masked_alu
  import simd_pkg::*;
#(
  parameter int VEC_W = 512,
  parameter int KW    = VEC_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        lane_sz,
  input  logic              is_signed,
  input  logic              zero_mode,
  input  logic [KW-1:0]     kmask,
  input  logic [VEC_W-1:0]  opa,
  input  logic [VEC_W-1:0]  opb,
  input  logic [VEC_W-1:0]  src,
  output logic [VEC_W-1:0]  result,
  output logic              out_valid,
  output logic              illegal
);
  simd_op_e            op_e;
  logic [VEC_W-1:0]    by_size [NUM_SIZES];
  logic [VEC_W-1:0]    picked;
  logic                wide_sat, accept;

  assign op_e = simd_op_e'(op);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    simd_width_slice #(.VEC_W(VEC_W), .W(8 << g), .KW(KW)) u_slice (
      .op       (op_e),
      .sgn      (is_signed),
      .zero_mode(zero_mode),
      .kmask    (kmask),
      .a        (opa),
      .b        (opb),
      .src      (src),
      .y        (by_size[g])
    );
  end

  assign picked   = by_size[lane_sz];
  assign wide_sat = op_saturates(op_e) && lane_sz[1];
  assign accept   = in_valid && !wide_sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= accept;
      illegal   <= in_valid && wide_sat;
      if (accept) result <= picked;
    end
  end

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(result) && !out_valid);
  p_reject_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_saturates(op_e) && lane_sz[1]) |=> illegal && !out_valid);
  p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(illegal && out_valid));
endmodule

// File: tb/simd_masked_alu_test.sv
module simd_masked_alu_test;
  localparam int VW = 64;
  localparam int KW = VW / 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [2:0]    op;
  logic [1:0]    lane_sz;
  logic          is_signed, zero_mode;
  logic [KW-1:0] kmask;
  logic [VW-1:0] opa, opb, src;
  logic [VW-1:0] result;
  logic          out_valid, illegal;

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] last_res;

  always #5 clk = ~clk;

  simd_masked_alu #(.VEC_W(VW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .is_signed(is_signed), .zero_mode(zero_mode), .kmask(kmask),
    .opa(opa), .opb(opb), .src(src),
    .result(result), .out_valid(out_valid), .illegal(illegal)
  );

  task automatic check(string tag, logic [VW-1:0] got, logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [VW-1:0] model(int o, int sz, bit sg, bit zm,
      logic [KW-1:0] k, logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] s);
    int w = 8 << sz;
    int nl = VW / w;
    logic [63:0] lm = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [VW-1:0] out = '0;
    logic signed [67:0] lo, hi, one;
    one = 68'sd1;
    lo = sg ? -(one <<< (w-1)) : 68'sd0;
    hi = sg ? ((one <<< (w-1)) - 1) : ((one <<< w) - 1);
    for (int i = 0; i < nl; i++) begin
      logic [63:0] la, lb, ls, r;
      logic signed [67:0] ea, eb, sa, t;
      la = (a >> (i*w)) & lm;
      lb = (b >> (i*w)) & lm;
      ls = (s >> (i*w)) & lm;
      ea = {4'b0, la}; eb = {4'b0, lb};
      sa = ea;
      if (la[w-1]) sa = ea - (one <<< w);
      if (sg && la[w-1]) ea = ea - (one <<< w);
      if (sg && lb[w-1]) eb = eb - (one <<< w);
      case (o)
        0: t = ea + eb;
        1: t = ea - eb;
        2: begin t = ea + eb; if (t > hi) t = hi; if (t < lo) t = lo; end
        3: begin t = ea - eb; if (t > hi) t = hi; if (t < lo) t = lo; end
        4: t = (sa < 0) ? -sa : sa;
        5: t = (ea < eb) ? ea : eb;
        6: t = (ea < eb) ? eb : ea;
        default: t = k[i] ? eb : ea;
      endcase
      r = t[63:0] & lm;
      if (o != 7 && !k[i]) r = zm ? 64'd0 : ls;
      out = out | (VW'(r) << (i*w));
    end
    return out;
  endfunction

  function automatic string tag_of(int o, bit zm);
    string t;
    case (o)
      0, 1:    t = "R2";
      2, 3:    t = "R3";
      4:       t = "R5";
      5, 6:    t = "R4";
      default: t = "R8";
    endcase
    if (o != 7) t = {t, zm ? "/R6" : "/R7"};
    return t;
  endfunction

  // Drive one request, sample half a cycle after the capturing edge
  task automatic issue(int o, int sz, bit sg, bit zm, logic [KW-1:0] k,
      logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] s, string tag);
    logic [VW-1:0] exp;
    bit bad = (o == 2 || o == 3) && sz >= 2;
    @(negedge clk);
    op = 3'(o); lane_sz = 2'(sz); is_signed = sg; zero_mode = zm;
    kmask = k; opa = a; opb = b; src = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (bad) begin
      check("R11 illegal", {63'd0, illegal}, 64'd1);
      check("R11 out_valid", {63'd0, out_valid}, 64'd0);
      check("R11 result kept", result, last_res);
    end else begin
      exp = model(o, sz, sg, zm, k, a, b, s);
      check({tag, " valid R10"}, {63'd0, out_valid}, 64'd1);
      check(tag, result, exp);
      last_res = exp;
    end
    @(negedge clk);
    check("R10 pulse ends", {62'd0, out_valid, illegal}, 64'd0);
    check("R10 hold", result, last_res);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; lane_sz = '0; is_signed = 1'b0;
    zero_mode = 1'b0; kmask = '0; opa = '0; opb = '0; src = '0;
    last_res = '0;
    repeat (3) @(negedge clk);
    check("R12 reset result", result, '0);
    check("R12 reset flags", {62'd0, out_valid, illegal}, 64'd0);
    rst = 1'b0;

    // R1: carry does not cross a 32-bit lane boundary
    issue(0, 2, 0, 1, 8'hFF, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001,
          '0, "R1 lane carry");
    // R5: most negative byte wraps
    issue(4, 0, 1, 1, 8'hFF, {8{8'h80}}, '0, '0, "R5 abs min");
    // R3: signed and unsigned byte clamps
    issue(2, 0, 1, 1, 8'hFF, {8{8'h7F}}, {8{8'h01}}, '0, "R3 signed top");
    issue(3, 1, 0, 1, 8'hFF, {4{16'h0001}}, {4{16'h0002}}, '0, "R3 unsigned floor");
    // R9: upper mask bits ignored at 16-bit lanes
    issue(0, 1, 0, 1, 8'hF0, {4{16'h1234}}, {4{16'h1111}}, '1, "R9 upper mask");
    check("R9 zero result", result, '0);
    // R11: wide saturation rejected
    issue(2, 2, 1, 0, 8'hFF, '1, '1, '1, "R11");
    issue(3, 3, 0, 1, 8'hFF, '1, '0, '0, "R11");

    // Near-exhaustive sweep
    for (int o = 0; o < 8; o++)
      for (int sz = 0; sz < 4; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int zm = 0; zm < 2; zm++)
            for (int n = 0; n < 6; n++) begin
              logic [VW-1:0] a, b, s;
              a = {$urandom, $urandom};
              b = {$urandom, $urandom};
              s = {$urandom, $urandom};
              if (n == 0) begin a = {8{8'h7F}}; b = {8{8'h81}}; end
              if (n == 1) begin a = {8{8'h80}}; b = {8{8'h7F}}; end
              issue(o, sz, sg[0], zm[0], KW'($urandom), a, b, s, tag_of(o, zm[0]));
            end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule